// File: doc/BRIEF.md
# Transmit descriptor ring walker

This block walks a ring of transmit descriptors that software places in system memory. A one-cycle poll pulse starts the walk. For each descriptor, the block reads the control word, the size word and the buffer address over a word-wide memory master port. The master port has a single outstanding request and uses a request/acknowledge handshake. If software owns the descriptor, the block fetches the buffer bytes and streams them on a valid/ready byte interface. Several segments can make up one frame, and the last byte of a frame is flagged.

After a segment has been sent, the block writes the control word back with the ownership flag cleared. The current-descriptor pointer then either moves to the next 32-byte slot or returns to the ring base. The walk stops at the first descriptor that the block does not own. A poll that arrives during a walk is remembered and causes one more pass. Three sticky status flags report:

- a completed frame;
- a summary of normal events;
- a segment that was cut to the maximum length.

Software clears these flags with write-one-to-clear pulses.

The reset input is asserted asynchronously and is released in step with the clock inside the block. The current-descriptor pointer is visible as an output.

Top module: `txr_walker`

## Requirements
- R1: A `poll_req` pulse while idle starts a walk. Each step reads the control word at `cur_ptr`. If bit 31 (ownership) of that word is 0, the walk ends: no further memory access is made and `busy` falls.
- R2: The segment length is the size word's bits [11:0] plus its bits [27:16]. Bits [15:12] and [31:28] are ignored. The size word is at descriptor offset 4, and the buffer byte address is at offset 8. Bytes go out in ascending address order from any start alignment, and byte lane k of a memory word is bits [8k+7:8k].
- R3: `tx_last` is high only with the final byte of a segment whose control bit 29 is 1. A segment without bit 29 leaves the frame open for the next segment.
- R4: After a segment, exactly one memory write is made: the control word, to the descriptor address, with bit 31 cleared and every other bit as read. The other descriptor words are not written.
- R5: After the write-back, `cur_ptr` reloads the ring base if control bit 21 is 1, and otherwise advances by 32.
- R6: A `base_wr` pulse loads `base_wdata` into both the ring base and `cur_ptr` on the next clock. It takes priority over an advance in the same cycle.
- R7: When a segment with bit 29 completes, `stat` bit 0 (frame sent) and bit 1 (normal summary) are set. Each `stat` bit stays set until a 1 on the matching `stat_clr` bit clears it. A set in the same cycle as a clear wins.
- R8: A computed length above 2048 is cut to exactly 2048 bytes, and `stat` bit 2 (abort) is set.
- R9: A `poll_req` pulse during a walk causes exactly one more pass after the walk ends. That pass starts by reading the control word at `cur_ptr` again.
- R10: While `tx_valid` is high and `tx_ready` is low, `tx_valid`, `tx_data` and `tx_last` hold their values.
- R11: A memory request holds its address, direction and write data until acknowledged. It is never raised together with `tx_valid`.
- R12: After reset, `busy`, `mem_req`, `tx_valid`, `stat` and `cur_ptr` are all 0.
- R13: A segment of length 0 emits no byte. It is still written back, and if bit 29 is set it still sets the status flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| poll_req | input | 1 | One-cycle request to walk the ring |
| base_wr | input | 1 | Load ring base and current pointer |
| base_wdata | input | AW | Ring base byte address (32-byte aligned) |
| stat_clr | input | 3 | Write-one-to-clear for the status flags |
| stat | output | 3 | Sticky flags: 0 frame sent, 1 summary, 2 abort |
| cur_ptr | output | AW | Current descriptor byte address |
| busy | output | 1 | Walk running or pass pending |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | AW | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request completes; read data valid |
| mem_rdata | input | 32 | Read data |
| tx_valid | output | 1 | Frame byte valid |
| tx_ready | input | 1 | Sink accepts byte |
| tx_data | output | 8 | Frame byte |
| tx_last | output | 1 | Final byte of a frame |

## Verification
A wrong sequencer state shows at once as an unexpected memory address or an out-of-order byte. The byte scoreboard catches a misplaced lane or a wrongly counted length on the very transfer where it goes wrong. A miscounted remaining length or a wrong last-segment flag appears as `tx_last` on the wrong byte, or as a frame with the wrong number of bytes. A bad pointer update appears at the write-back of that descriptor or at the next control-word fetch, within a few cycles. A dropped pending poll appears only when the walk ends: the stop descriptor is re-read too few times.

// File: rtl/txr_pkg.sv
package txr_pkg;
  // memory word and descriptor geometry
  localparam int WORD_W     = 32;
  localparam int DESC_BYTES = 32;
  localparam int SIZE_W     = 12;
  localparam int SEG_LEN_W  = SIZE_W + 1;
  localparam int B2_LSB     = 16;
  // byte offsets of the fetched descriptor words
  localparam int OFS_SIZE   = 4;
  localparam int OFS_BUF    = 8;
  // control word bit positions
  localparam int OWN_BIT    = 31;
  localparam int LAST_BIT   = 29;
  localparam int WRAP_BIT   = 21;
  // status flag positions
  localparam int ST_DONE    = 0;
  localparam int ST_SUM     = 1;
  localparam int ST_ABORT   = 2;
  localparam int ST_W       = 3;

  typedef enum logic [2:0] {
    S_IDLE,
    S_CTL,
    S_SIZE,
    S_BUF,
    S_DATA,
    S_SEND,
    S_WB
  } txr_state_e;
endpackage

// File: rtl/txr_rst_sync.sv
module txr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/txr_ptr.sv
module txr_ptr
  import txr_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          base_wr,
  input  logic [AW-1:0] base_wdata,
  input  logic          adv,
  input  logic          wrap,
  output logic [AW-1:0] base_q,
  output logic [AW-1:0] cur_q
);
  localparam logic [AW-1:0] STEP = AW'(DESC_BYTES);

  logic [AW-1:0] base_d, cur_d;
  logic          base_en, cur_en;

  always_comb begin
    base_en = base_wr;
    base_d  = base_wdata;
    cur_en  = base_wr | adv;
    if (base_wr)   cur_d = base_wdata;   // software load wins
    else if (wrap) cur_d = base_q;
    else           cur_d = cur_q + STEP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      cur_q  <= '0;
    end else begin
      if (base_en) base_q <= base_d;
      if (cur_en)  cur_q  <= cur_d;
    end
  end
endmodule

// File: rtl/txr_status.sv
module txr_status
  import txr_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            set_done,
  input  logic            set_abort,
  input  logic [ST_W-1:0] clr,
  output logic [ST_W-1:0] stat_q
);
  logic [ST_W-1:0] set_v, stat_d;

  always_comb begin
    set_v           = '0;
    set_v[ST_DONE]  = set_done;
    set_v[ST_SUM]   = set_done;
    set_v[ST_ABORT] = set_abort;
    stat_d          = set_v | (stat_q & ~clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= stat_d;
  end
endmodule

// File: rtl/txr_seq.sv
module txr_seq
  import txr_pkg::*;
#(
  parameter int AW      = 32,
  parameter int MAX_SEG = 2048
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              poll_req,
  input  logic [AW-1:0]     cur_ptr,
  output logic              mem_req,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [7:0]        tx_data,
  output logic              tx_last,
  output logic              adv,
  output logic              wrap,
  output logic              set_done,
  output logic              set_abort,
  output logic              busy
);
  localparam int                 LENW    = SEG_LEN_W;
  localparam logic [LENW-1:0]    MAX_LEN = LENW'(MAX_SEG);
  localparam logic [LENW-1:0]    ONE     = LENW'(1);
  localparam logic [AW-1:0]      A_SIZE  = AW'(OFS_SIZE);
  localparam logic [AW-1:0]      A_BUF   = AW'(OFS_BUF);
  localparam logic [WORD_W-1:0]  OWN_MSK = WORD_W'(1) << OWN_BIT;

  txr_state_e        state_q, state_d;
  logic              pend_q, pend_d;
  logic [WORD_W-1:0] ctl_q, ctl_d;
  logic [WORD_W-1:0] word_q, word_d;
  logic [LENW-1:0]   len_q, len_d;
  logic [AW-1:0]     baddr_q, baddr_d;
  logic [LENW-1:0]   seg_sum;

  // next-state process
  always_comb begin
    state_d   = state_q;
    pend_d    = pend_q;
    ctl_d     = ctl_q;
    word_d    = word_q;
    len_d     = len_q;
    baddr_d   = baddr_q;
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = cur_ptr;
    mem_wdata = '0;
    tx_valid  = 1'b0;
    tx_last   = 1'b0;
    adv       = 1'b0;
    set_done  = 1'b0;
    set_abort = 1'b0;
    seg_sum   = LENW'(mem_rdata[SIZE_W-1:0]) + LENW'(mem_rdata[B2_LSB +: SIZE_W]);

    if (poll_req && (state_q != S_IDLE)) pend_d = 1'b1;

    unique case (state_q)
      S_IDLE: begin
        if (poll_req || pend_q) begin
          state_d = S_CTL;
          pend_d  = 1'b0;
        end
      end
      S_CTL: begin
        mem_req = 1'b1;
        if (mem_ack) begin
          ctl_d   = mem_rdata;
          state_d = mem_rdata[OWN_BIT] ? S_SIZE : S_IDLE;
        end
      end
      S_SIZE: begin
        mem_req  = 1'b1;
        mem_addr = cur_ptr + A_SIZE;
        if (mem_ack) begin
          if (seg_sum > MAX_LEN) begin
            len_d     = MAX_LEN;
            set_abort = 1'b1;
          end else begin
            len_d = seg_sum;
          end
          state_d = S_BUF;
        end
      end
      S_BUF: begin
        mem_req  = 1'b1;
        mem_addr = cur_ptr + A_BUF;
        if (mem_ack) begin
          baddr_d = mem_rdata[AW-1:0];
          state_d = (len_q == '0) ? S_WB : S_DATA;
        end
      end
      S_DATA: begin
        mem_req  = 1'b1;
        mem_addr = {baddr_q[AW-1:2], 2'b00};
        if (mem_ack) begin
          word_d  = mem_rdata;
          state_d = S_SEND;
        end
      end
      S_SEND: begin
        tx_valid = 1'b1;
        tx_last  = ctl_q[LAST_BIT] && (len_q == ONE);
        if (tx_ready) begin
          baddr_d = baddr_q + AW'(1);
          len_d   = len_q - ONE;
          if (len_q == ONE)               state_d = S_WB;
          else if (baddr_q[1:0] == 2'b11) state_d = S_DATA;
        end
      end
      S_WB: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_wdata = ctl_q & ~OWN_MSK;
        if (mem_ack) begin
          adv      = 1'b1;
          set_done = ctl_q[LAST_BIT];
          state_d  = S_CTL;
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  assign tx_data = word_q[{baddr_q[1:0], 3'b000} +: 8];
  assign wrap    = ctl_q[WRAP_BIT];
  assign busy    = (state_q != S_IDLE) || pend_q;

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      pend_q  <= 1'b0;
      ctl_q   <= '0;
      word_q  <= '0;
      len_q   <= '0;
      baddr_q <= '0;
    end else begin
      state_q <= state_d;
      pend_q  <= pend_d;
      ctl_q   <= ctl_d;
      word_q  <= word_d;
      len_q   <= len_d;
      baddr_q <= baddr_d;
    end
  end
endmodule

// File: rtl/txr_walker.sv
module txr_walker
  import txr_pkg::*;
#(
  parameter int AW      = 32,
  parameter int MAX_SEG = 2048
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              poll_req,
  input  logic              base_wr,
  input  logic [AW-1:0]     base_wdata,
  input  logic [ST_W-1:0]   stat_clr,
  output logic [ST_W-1:0]   stat,
  output logic [AW-1:0]     cur_ptr,
  output logic              busy,
  output logic              mem_req,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [7:0]        tx_data,
  output logic              tx_last
);
  logic          rst_s;
  logic [AW-1:0] base_q;
  logic          adv, wrap, set_done, set_abort;

  txr_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_s)
  );

  txr_ptr #(.AW(AW)) u_ptr (
    .clk        (clk),
    .rst_n      (rst_s),
    .base_wr    (base_wr),
    .base_wdata (base_wdata),
    .adv        (adv),
    .wrap       (wrap),
    .base_q     (base_q),
    .cur_q      (cur_ptr)
  );

  txr_status u_stat (
    .clk       (clk),
    .rst_n     (rst_s),
    .set_done  (set_done),
    .set_abort (set_abort),
    .clr       (stat_clr),
    .stat_q    (stat)
  );

  txr_seq #(.AW(AW), .MAX_SEG(MAX_SEG)) u_seq (
    .clk       (clk),
    .rst_n     (rst_s),
    .poll_req  (poll_req),
    .cur_ptr   (cur_ptr),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_ack   (mem_ack),
    .mem_rdata (mem_rdata),
    .tx_valid  (tx_valid),
    .tx_ready  (tx_ready),
    .tx_data   (tx_data),
    .tx_last   (tx_last),
    .adv       (adv),
    .wrap      (wrap),
    .set_done  (set_done),
    .set_abort (set_abort),
    .busy      (busy)
  );
endmodule

// File: rtl/txr_checker.sv
module txr_checker #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tx_valid,
  input logic          tx_ready,
  input logic [7:0]    tx_data,
  input logic          tx_last,
  input logic          mem_req,
  input logic          mem_we,
  input logic          mem_ack,
  input logic [AW-1:0] mem_addr,
  input logic [31:0]   mem_wdata,
  input logic          base_wr,
  input logic [AW-1:0] base_wdata,
  input logic [AW-1:0] base_q,
  input logic [AW-1:0] cur_ptr,
  input logic [2:0]    stat,
  input logic [2:0]    stat_clr
);
  assert_last_with_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_last |-> tx_valid);

  assert_hold_on_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));

  assert_req_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack && !base_wr) |=>
      (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  assert_no_overlap_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req && tx_valid));

  assert_wb_owner_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> !mem_wdata[31]);

  assert_base_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    base_wr |=> (cur_ptr == $past(base_wdata)));

  assert_ptr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !base_wr |=> ($stable(cur_ptr) || (cur_ptr == $past(cur_ptr) + AW'(32)) ||
                  (cur_ptr == base_q)));

  assert_done_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (stat[0] && !stat_clr[0]) |=> stat[0]);

  assert_abort_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (stat[2] && !stat_clr[2]) |=> stat[2]);
endmodule

bind txr_walker txr_checker #(.AW(AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_s),
  .tx_valid   (tx_valid),
  .tx_ready   (tx_ready),
  .tx_data    (tx_data),
  .tx_last    (tx_last),
  .mem_req    (mem_req),
  .mem_we     (mem_we),
  .mem_ack    (mem_ack),
  .mem_addr   (mem_addr),
  .mem_wdata  (mem_wdata),
  .base_wr    (base_wr),
  .base_wdata (base_wdata),
  .base_q     (base_q),
  .cur_ptr    (cur_ptr),
  .stat       (stat),
  .stat_clr   (stat_clr)
);

// File: tb/sim_txr_walker.sv
`timescale 1ns/1ps
module sim_txr_walker;
  localparam int AW = 32;
  localparam logic [31:0] OWN  = 32'h8000_0000;
  localparam logic [31:0] LAST = 32'h2000_0000;
  localparam logic [31:0] WRAP = 32'h0020_0000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          poll_req = 1'b0;
  logic          base_wr = 1'b0;
  logic [AW-1:0] base_wdata = '0;
  logic [2:0]    stat_clr = '0;
  logic [2:0]    stat;
  logic [AW-1:0] cur_ptr;
  logic          busy;
  logic          mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [31:0]   mem_wdata;
  logic          mem_ack = 1'b0;
  logic [31:0]   mem_rdata = '0;
  logic          tx_valid;
  logic          tx_ready = 1'b0;
  logic [7:0]    tx_data;
  logic          tx_last;

  always #5 clk = ~clk;

  txr_walker #(.AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .poll_req(poll_req), .base_wr(base_wr),
    .base_wdata(base_wdata), .stat_clr(stat_clr), .stat(stat), .cur_ptr(cur_ptr),
    .busy(busy), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .tx_last(tx_last)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int writes = 0;
  int watch_reads = 0;
  logic [AW-1:0] watch_addr = '1;
  logic [7:0] mem [0:4095];
  logic [8:0] exp_q [$];

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic put_word(input int a, input logic [31:0] w);
    for (int k = 0; k < 4; k++) mem[(a + k) & 4095] = w[8*k +: 8];
  endtask

  function automatic logic [31:0] get_word(input int a);
    return {mem[(a+3) & 4095], mem[(a+2) & 4095], mem[(a+1) & 4095], mem[a & 4095]};
  endfunction

  task automatic make_desc(input int d, input logic [31:0] ctl, input logic [31:0] sz,
                           input int ba);
    put_word(d, ctl);
    put_word(d + 4, sz);
    put_word(d + 8, ba);
    put_word(d + 12, 32'hB2B2_0000 | d);
    put_word(d + 16, 32'hE5E5_0000 | d);
    for (int k = 20; k < 32; k += 4) put_word(d + k, 32'h5A5A_5A5A);
  endtask

  task automatic fill(input int ba, input int n, input int seed);
    for (int i = 0; i < n; i++) mem[(ba + i) & 4095] = 8'(seed + 3*i);
  endtask

  // driver side of the scoreboard: expected bytes of one segment
  task automatic push_seg(input int ba, input int n, input bit last);
    for (int i = 0; i < n; i++) exp_q.push_back({last && (i == n - 1), mem[(ba + i) & 4095]});
  endtask

  task automatic pulse_poll();
    @(negedge clk) poll_req = 1'b1;
    @(negedge clk) poll_req = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  task automatic load_base(input int b);
    @(negedge clk) begin base_wr = 1'b1; base_wdata = b; end
    @(negedge clk) base_wr = 1'b0;
  endtask

  task automatic clear_stat(input logic [2:0] m);
    @(negedge clk) stat_clr = m;
    @(negedge clk) stat_clr = '0;
  endtask

  // memory responder, sink pacing and monitor
  always @(negedge clk) begin
    int a;
    logic [8:0] e;
    cyc++;
    tx_ready = ((cyc % 7) != 3) && ((cyc % 7) != 4);
    if (mem_ack) begin
      mem_ack = 1'b0;
    end else if (rst_n && mem_req) begin
      a = int'(mem_addr[11:0]) & ~3;
      if (mem_we) begin
        for (int k = 0; k < 4; k++) mem[a + k] = mem_wdata[8*k +: 8];
        writes++;
      end else begin
        mem_rdata = get_word(a);
        if (mem_addr == watch_addr) watch_reads++;
      end
      mem_ack = 1'b1;
    end
    if (tx_valid && tx_ready) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R2 unexpected byte", {tx_last, tx_data}, 0);
      end else begin
        e = exp_q.pop_front();
        chk({tx_last, tx_data} == e, "R2/R3 stream byte", {tx_last, tx_data}, e);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog", cyc, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R12 reset state
    chk(!busy && !mem_req && !tx_valid, "R12 idle outputs", {busy, mem_req, tx_valid}, 0);
    chk(stat == 3'b000, "R12 stat", stat, 0);
    chk(cur_ptr == 0, "R12 cur_ptr", cur_ptr, 0);

    // R6 base load
    load_base(32'h100);
    chk(cur_ptr == 32'h100, "R6 base load", cur_ptr, 32'h100);

    // single frame, R1/R2/R3/R4/R5/R7
    make_desc(32'h100, OWN | LAST | 32'h0000_00F5, 32'd8, 32'h800);
    make_desc(32'h120, 32'h0, 32'h0, 0);
    fill(32'h800, 8, 8'h11);
    push_seg(32'h800, 8, 1'b1);
    writes = 0; watch_addr = 32'h120; watch_reads = 0;
    pulse_poll();
    wait_idle();
    chk(exp_q.size() == 0, "R2 all bytes sent", exp_q.size(), 0);
    chk(get_word(32'h100) == (LAST | 32'h0000_00F5), "R4 wb word", get_word(32'h100),
        LAST | 32'h0000_00F5);
    chk(get_word(32'h104) == 32'd8 && get_word(32'h108) == 32'h800, "R4 other words",
        get_word(32'h104), 8);
    chk(writes == 1, "R4 one write", writes, 1);
    chk(cur_ptr == 32'h120, "R5 advance", cur_ptr, 32'h120);
    chk(stat == 3'b011, "R7 done flags", stat, 3'b011);
    chk(watch_reads == 1, "R1 stop read once", watch_reads, 1);
    chk(get_word(32'h120) == 0, "R1 stop desc untouched", get_word(32'h120), 0);

    // R7 w1c
    clear_stat(3'b011);
    chk(stat == 3'b000, "R7 clear", stat, 0);

    // two-segment frame, unaligned buffer, both size fields (R2, R3)
    make_desc(32'h120, OWN, {16'd2, 16'd3}, 32'h901);
    make_desc(32'h140, OWN | LAST, 32'd4, 32'hA02);
    make_desc(32'h160, OWN, 32'd2, 32'hB00);
    make_desc(32'h180, 32'h0, 32'h0, 0);
    fill(32'h901, 5, 8'h40);
    fill(32'hA02, 4, 8'h70);
    fill(32'hB00, 2, 8'h90);
    push_seg(32'h901, 5, 1'b0);
    push_seg(32'hA02, 4, 1'b1);
    push_seg(32'hB00, 2, 1'b0);
    pulse_poll();
    wait_idle();
    chk(exp_q.size() == 0, "R3 segments sent", exp_q.size(), 0);
    chk(cur_ptr == 32'h180, "R5 three steps", cur_ptr, 32'h180);
    chk(stat == 3'b011, "R7 only last sets", stat, 3'b011);
    clear_stat(3'b011);
    // a segment without bit 29 alone must not set the flags
    make_desc(32'h180, OWN, 32'd2, 32'hB00);
    make_desc(32'h1A0, 32'h0, 32'h0, 0);
    push_seg(32'hB00, 2, 1'b0);
    pulse_poll();
    wait_idle();
    chk(stat == 3'b000, "R7 no flag without last", stat, 0);

    // truncation with masked upper size bits (R8, R2)
    make_desc(32'h1A0, OWN | LAST, {16'hF000 | 16'd1000, 16'hF000 | 16'd2000}, 32'h800);
    make_desc(32'h1C0, OWN | LAST | WRAP, 32'd4, 32'h800);
    fill(32'h800, 2048, 8'h05);
    push_seg(32'h800, 2048, 1'b1);
    push_seg(32'h800, 4, 1'b1);
    watch_addr = 32'h100; watch_reads = 0;
    pulse_poll();
    wait_idle();
    chk(exp_q.size() == 0, "R8 truncated length", exp_q.size(), 0);
    chk(stat == 3'b111, "R8 abort flag", stat, 3'b111);
    // wrap bit on 0x1C0 returns to base; base desc no longer owned
    chk(cur_ptr == 32'h100, "R5 wrap", cur_ptr, 32'h100);
    chk(watch_reads == 1, "R5 fetch at base", watch_reads, 1);
    clear_stat(3'b100);
    chk(stat == 3'b011, "R7 clear only abort", stat, 3'b011);
    clear_stat(3'b011);

    // zero-length last segment (R13) at a new base (R6)
    load_base(32'h200);
    chk(cur_ptr == 32'h200, "R6 reload", cur_ptr, 32'h200);
    make_desc(32'h200, OWN | LAST, {16'hF000, 16'hF000}, 32'h800);
    make_desc(32'h220, 32'h0, 32'h0, 0);
    pulse_poll();
    wait_idle();
    chk(get_word(32'h200) == LAST, "R13 wb", get_word(32'h200), LAST);
    chk(stat == 3'b011, "R13 flags", stat, 3'b011);
    chk(cur_ptr == 32'h220, "R13 advance", cur_ptr, 32'h220);

    // poll during walk (R9)
    make_desc(32'h220, OWN | LAST, 32'd40, 32'hC00);
    make_desc(32'h240, 32'h0, 32'h0, 0);
    fill(32'hC00, 40, 8'hA1);
    push_seg(32'hC00, 40, 1'b1);
    watch_addr = 32'h240; watch_reads = 0;
    pulse_poll();
    repeat (6) @(negedge clk);
    chk(busy == 1'b1, "R9 busy in walk", busy, 1);
    pulse_poll();
    wait_idle();
    chk(exp_q.size() == 0, "R9 frame sent", exp_q.size(), 0);
    chk(watch_reads == 2, "R9 extra pass", watch_reads, 2);
    chk(cur_ptr == 32'h240, "R9 pointer", cur_ptr, 32'h240);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule